// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small processor core down into one of two low-power states and back out again. A sleep request from the core carries a tag that says whether it came from a wait-for-interrupt or a wait-for-event instruction. The request is qualified by a deep-sleep control bit. A power-down select bit then picks between two states. Stop keeps the core voltage domain alive with its clocks halted. Standby removes the core supply entirely.

Before it commits, the sequencer looks at the per-line external pending flags and at the RTC alarm. A request made while any of them is set is dropped. A wake source that shows up during the single entry cycle cancels the descent.

The sequencer leaves Stop only on a line that suits the instruction used to enter. After such a wake it counts out the regulator recovery time, when the low-power regulator was chosen, and then the internal RC startup time. It then hands the core back with the system clock forced to the internal RC and raises a one-cycle done strobe. A wake from Standby instead raises a one-cycle system reset request. The always-on watchdog, RTC and low-speed oscillator enables pass through unchanged in every state, and the watchdog enable is sticky.

Top module: `pmc_lowpower_ctrl`

## Requirements
- R1: With deep-sleep 1 and power-down select 0, a sleep request with nothing pending gates the core clock (core_clk_en_o 0) from the next cycle. One cycle after that the block is in Stop, with PLL, external and internal high-speed oscillators all off.
- R2: With power-down select 1, the same request leads to Standby after the one-cycle entry step. In Standby reg_off_o is 1, core_dom_en_o is 0, and the PLL and both high-speed oscillators are off.
- R3: A sleep request while any line pending bit or the RTC alarm is set is ignored: the core clock stays enabled. A request with deep-sleep 0 is likewise ignored.
- R4: A pending line or the RTC alarm present during the entry cycle returns the block to run in the next cycle, with the core clock enabled again.
- R5: After a wait-for-interrupt entry (sleep_is_wfe_i 0), Stop is left only for a line that is pending, has its interrupt mode bit set and has its interrupt enable set.
- R6: After a wait-for-event entry (sleep_is_wfe_i 1), Stop is left only for a line that is pending and has its event mode bit set.
- R7: In Stop, reg_lp_req_o equals the regulator-mode bit sampled with the request. Outside Stop it is 0.
- R8: The wake latency from the clock edge that samples the wake source to the edge that raises wake_done_o is RC_START_CYC cycles. It is RC_START_CYC + REG_RECOV_CYC cycles when the low-power regulator was chosen. The internal RC is re-enabled only for the final RC_START_CYC cycles.
- R9: wake_done_o lasts exactly one cycle. When it is high the core clock is enabled and sysclk_sel_o is 0 (internal RC). Codes 1 and 2 stand for the external oscillator and the PLL, and are written in run via clk_sel_wr_i.
- R10: In Standby, wake_pin_i or the RTC alarm gives a one-cycle sys_rst_req_o, returns the block to run and sets sysclk_sel_o to 0.
- R11: rtc_run_o, lsi_run_o and lse_run_o follow their enables one cycle later in every state. wdg_run_o sets on wdg_start_i and clears only on reset.
- R12: After reset the block is in run, with the core clock enabled, all oscillators on, sysclk_sel_o 0 and every strobe and watchdog output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Core sleep request pulse |
| sleep_is_wfe_i | input | 1 | 1: request from wait-for-event, 0: wait-for-interrupt |
| deep_sleep_i | input | 1 | Deep-sleep control bit |
| pdown_sel_i | input | 1 | 0: Stop, 1: Standby |
| reg_lp_sel_i | input | 1 | Regulator to low-power mode during Stop |
| line_pend_i | input | NUM_LINES | External line pending flags |
| line_irq_mode_i | input | NUM_LINES | Line configured for interrupt mode |
| line_irq_en_i | input | NUM_LINES | Line interrupt enabled at the controller |
| line_evt_mode_i | input | NUM_LINES | Line configured for event mode |
| rtc_alarm_i | input | 1 | RTC alarm flag |
| wake_pin_i | input | 1 | Standby wake pin |
| clk_sel_wr_i | input | 1 | System clock select write strobe |
| clk_sel_val_i | input | 2 | System clock select write value |
| wdg_start_i | input | 1 | Watchdog start pulse |
| rtc_en_i | input | 1 | RTC enable |
| lsi_en_i | input | 1 | Low-speed internal RC enable |
| lse_en_i | input | 1 | 32.768 kHz oscillator enable |
| core_clk_en_o | output | 1 | Core clock enable |
| pll_off_o | output | 1 | PLL disable |
| hse_off_o | output | 1 | External high-speed oscillator disable |
| hsi_off_o | output | 1 | Internal high-speed RC disable |
| reg_lp_req_o | output | 1 | Regulator low-power request |
| reg_off_o | output | 1 | Regulator off (Standby) |
| core_dom_en_o | output | 1 | Core power domain enable |
| sysclk_sel_o | output | 2 | System clock source select |
| wake_done_o | output | 1 | One-cycle wake completion strobe |
| sys_rst_req_o | output | 1 | One-cycle system reset request on Standby exit |
| wdg_run_o | output | 1 | Watchdog running (sticky) |
| rtc_run_o | output | 1 | RTC running |
| lsi_run_o | output | 1 | Low-speed RC running |
| lse_run_o | output | 1 | 32.768 kHz oscillator running |

## Verification
The entry decision is driven by four kinds of request: one with deep-sleep cleared, one with a line pending, one with only the RTC alarm set, and a clean one. These tell the two abort conditions apart from the accept path. Wake from Stop is tried with a pending line whose mode does not suit the entry instruction, followed by one whose mode does. This is done once for each instruction type, so a swapped or merged wake qualifier is caught. The two regulator choices give different latencies, and the bench counts each one exactly. Cancel in the entry cycle, Standby exit by pin and by alarm, and a reset in the middle of a run separate the remaining transitions.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_ENTER   = 3'd1,
    ST_STOP    = 3'd2,
    ST_WREG    = 3'd3,
    ST_WRC     = 3'd4,
    ST_STANDBY = 3'd5
  } pmc_state_e;

  localparam logic [1:0] CLK_RC   = 2'd0;
  localparam logic [1:0] CLK_XTAL = 2'd1;
  localparam logic [1:0] CLK_PLL  = 2'd2;

  typedef struct packed {
    logic core_clk_en;
    logic pll_off;
    logic hse_off;
    logic hsi_off;
    logic reg_lp;
    logic reg_off;
    logic dom_en;
  } pmc_pwr_t;

  localparam pmc_pwr_t PWR_RUN = '{core_clk_en: 1'b1, pll_off: 1'b0, hse_off: 1'b0,
                                   hsi_off: 1'b0, reg_lp: 1'b0, reg_off: 1'b0, dom_en: 1'b1};

endpackage

// File: rtl/pmc_wake_eval.sv
module pmc_wake_eval #(
  parameter int NUM_LINES = 4
) (
  input  logic [NUM_LINES-1:0] line_pend_i,
  input  logic [NUM_LINES-1:0] line_irq_mode_i,
  input  logic [NUM_LINES-1:0] line_irq_en_i,
  input  logic [NUM_LINES-1:0] line_evt_mode_i,
  input  logic                 rtc_alarm_i,
  output logic                 pend_any_o,
  output logic                 irq_wake_o,
  output logic                 evt_wake_o
);
  logic [NUM_LINES-1:0] irq_hit;
  logic [NUM_LINES-1:0] evt_hit;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign irq_hit[g] = line_pend_i[g] & line_irq_mode_i[g] & line_irq_en_i[g];
    assign evt_hit[g] = line_pend_i[g] & line_evt_mode_i[g];
  end

  assign pend_any_o = (|line_pend_i) | rtc_alarm_i;
  assign irq_wake_o = |irq_hit;
  assign evt_wake_o = |evt_hit;
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && zero_o) |=> zero_o); // R8
endmodule

// File: rtl/pmc_aon_keep.sv
module pmc_aon_keep (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wdg_start_i,
  input  logic rtc_en_i,
  input  logic lsi_en_i,
  input  logic lse_en_i,
  output logic wdg_run_o,
  output logic rtc_run_o,
  output logic lsi_run_o,
  output logic lse_run_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wdg_run_o <= 1'b0;
      rtc_run_o <= 1'b0;
      lsi_run_o <= 1'b0;
      lse_run_o <= 1'b0;
    end else begin
      wdg_run_o <= wdg_run_o | wdg_start_i;
      rtc_run_o <= rtc_en_i;
      lsi_run_o <= lsi_en_i;
      lse_run_o <= lse_en_i;
    end
  end

  AST_WDG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    wdg_run_o |=> wdg_run_o); // R11
endmodule

// File: rtl/pmc_lowpower_ctrl.sv
module pmc_lowpower_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_LINES     = 4,
  parameter int RC_START_CYC  = 4,
  parameter int REG_RECOV_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 sleep_req_i,
  input  logic                 sleep_is_wfe_i,
  input  logic                 deep_sleep_i,
  input  logic                 pdown_sel_i,
  input  logic                 reg_lp_sel_i,
  input  logic [NUM_LINES-1:0] line_pend_i,
  input  logic [NUM_LINES-1:0] line_irq_mode_i,
  input  logic [NUM_LINES-1:0] line_irq_en_i,
  input  logic [NUM_LINES-1:0] line_evt_mode_i,
  input  logic                 rtc_alarm_i,
  input  logic                 wake_pin_i,
  input  logic                 clk_sel_wr_i,
  input  logic [1:0]           clk_sel_val_i,
  input  logic                 wdg_start_i,
  input  logic                 rtc_en_i,
  input  logic                 lsi_en_i,
  input  logic                 lse_en_i,
  output logic                 core_clk_en_o,
  output logic                 pll_off_o,
  output logic                 hse_off_o,
  output logic                 hsi_off_o,
  output logic                 reg_lp_req_o,
  output logic                 reg_off_o,
  output logic                 core_dom_en_o,
  output logic [1:0]           sysclk_sel_o,
  output logic                 wake_done_o,
  output logic                 sys_rst_req_o,
  output logic                 wdg_run_o,
  output logic                 rtc_run_o,
  output logic                 lsi_run_o,
  output logic                 lse_run_o
);
  localparam int MAX_CYC = (RC_START_CYC > REG_RECOV_CYC) ? RC_START_CYC : REG_RECOV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(RC_START_CYC - 1);
  localparam logic [CNT_W-1:0] REG_LOAD = CNT_W'(REG_RECOV_CYC - 1);

  pmc_state_e        st_q, st_d;
  logic              lp_q, wfe_q, sb_q;
  logic              pend_any, irq_wake, evt_wake, wake_ok;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  pmc_pwr_t          pwr_d, pwr_q;

  pmc_wake_eval #(.NUM_LINES(NUM_LINES)) u_wake (
    .line_pend_i     (line_pend_i),
    .line_irq_mode_i (line_irq_mode_i),
    .line_irq_en_i   (line_irq_en_i),
    .line_evt_mode_i (line_evt_mode_i),
    .rtc_alarm_i     (rtc_alarm_i),
    .pend_any_o      (pend_any),
    .irq_wake_o      (irq_wake),
    .evt_wake_o      (evt_wake)
  );

  pmc_settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pmc_aon_keep u_aon (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wdg_start_i (wdg_start_i),
    .rtc_en_i    (rtc_en_i),
    .lsi_en_i    (lsi_en_i),
    .lse_en_i    (lse_en_i),
    .wdg_run_o   (wdg_run_o),
    .rtc_run_o   (rtc_run_o),
    .lsi_run_o   (lsi_run_o),
    .lse_run_o   (lse_run_o)
  );

  assign wake_ok = wfe_q ? evt_wake : irq_wake;

  // Next-state and settle timer control
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = RC_LOAD;
    unique case (st_q)
      ST_RUN:     if (sleep_req_i && deep_sleep_i && !pend_any) st_d = ST_ENTER;
      ST_ENTER:   st_d = pend_any ? ST_RUN : (sb_q ? ST_STANDBY : ST_STOP);
      ST_STOP:    if (wake_ok) begin
                    tmr_load = 1'b1;
                    if (lp_q) begin
                      st_d    = ST_WREG;
                      tmr_val = REG_LOAD;
                    end else begin
                      st_d = ST_WRC;
                    end
                  end
      ST_WREG:    if (tmr_zero) begin
                    st_d     = ST_WRC;
                    tmr_load = 1'b1;
                  end
      ST_WRC:     if (tmr_zero) st_d = ST_RUN;
      ST_STANDBY: if (wake_pin_i || rtc_alarm_i) st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  // Power control decode of the state being entered
  always_comb begin
    pwr_d = PWR_RUN;
    unique case (st_d)
      ST_RUN:   pwr_d = PWR_RUN;
      ST_ENTER: pwr_d.core_clk_en = 1'b0;
      ST_STOP: begin
        pwr_d.core_clk_en = 1'b0;
        pwr_d.pll_off     = 1'b1;
        pwr_d.hse_off     = 1'b1;
        pwr_d.hsi_off     = 1'b1;
        pwr_d.reg_lp      = lp_q;
      end
      ST_WREG: begin
        pwr_d.core_clk_en = 1'b0;
        pwr_d.pll_off     = 1'b1;
        pwr_d.hse_off     = 1'b1;
        pwr_d.hsi_off     = 1'b1;
      end
      ST_WRC: begin
        pwr_d.core_clk_en = 1'b0;
        pwr_d.pll_off     = 1'b1;
        pwr_d.hse_off     = 1'b1;
      end
      ST_STANDBY: begin
        pwr_d.core_clk_en = 1'b0;
        pwr_d.pll_off     = 1'b1;
        pwr_d.hse_off     = 1'b1;
        pwr_d.hsi_off     = 1'b1;
        pwr_d.reg_off     = 1'b1;
        pwr_d.dom_en      = 1'b0;
      end
      default: pwr_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q          <= ST_RUN;
      lp_q          <= 1'b0;
      wfe_q         <= 1'b0;
      sb_q          <= 1'b0;
      pwr_q         <= PWR_RUN;
      sysclk_sel_o  <= CLK_RC;
      wake_done_o   <= 1'b0;
      sys_rst_req_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      pwr_q         <= pwr_d;
      wake_done_o   <= (st_q == ST_WRC) && (st_d == ST_RUN);
      sys_rst_req_o <= (st_q == ST_STANDBY) && (st_d == ST_RUN);
      if (st_q == ST_RUN && st_d == ST_ENTER) begin
        lp_q  <= reg_lp_sel_i;
        wfe_q <= sleep_is_wfe_i;
        sb_q  <= pdown_sel_i;
      end
      if (st_q == ST_RUN && clk_sel_wr_i)     sysclk_sel_o <= clk_sel_val_i;
      else if (st_q != ST_RUN && st_d == ST_RUN) sysclk_sel_o <= CLK_RC;
    end
  end

  assign core_clk_en_o = pwr_q.core_clk_en;
  assign pll_off_o     = pwr_q.pll_off;
  assign hse_off_o     = pwr_q.hse_off;
  assign hsi_off_o     = pwr_q.hsi_off;
  assign reg_lp_req_o  = pwr_q.reg_lp;
  assign reg_off_o     = pwr_q.reg_off;
  assign core_dom_en_o = pwr_q.dom_en;

  AST_ABORT_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_RUN && sleep_req_i && pend_any) |=> core_clk_en_o); // R3
  AST_ENTRY_CANCEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_ENTER && pend_any) |=> (st_q == ST_RUN && core_clk_en_o)); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_done_o |=> !wake_done_o); // R9
  AST_WAKE_ON_RC: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_done_o |-> (sysclk_sel_o == CLK_RC && core_clk_en_o)); // R9
  AST_RST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_req_o |=> !sys_rst_req_o); // R10
endmodule

// File: tb/pmc_lowpower_ctrl_tb.sv
module pmc_lowpower_ctrl_tb_top;
  localparam int N   = 4;
  localparam int RC  = 4;
  localparam int REG = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic sleep_req = 0, is_wfe = 0, deep = 0, pdsel = 0, lpsel = 0;
  logic [N-1:0] pend = '0, irqm = '0, irqe = '0, evtm = '0;
  logic rtc_alarm = 0, wake_pin = 0, sel_wr = 0;
  logic [1:0] sel_val = '0;
  logic wdg_start = 0, rtc_en = 0, lsi_en = 0, lse_en = 0;

  logic clk_en, pll_off, hse_off, hsi_off, reg_lp, reg_off, dom_en;
  logic [1:0] sysclk;
  logic wake_done, sys_rst, wdg_run, rtc_run, lsi_run, lse_run;

  pmc_lowpower_ctrl #(.NUM_LINES(N), .RC_START_CYC(RC), .REG_RECOV_CYC(REG)) dut_i (
    .clk_i(clk), .rst_i(rst), .sleep_req_i(sleep_req), .sleep_is_wfe_i(is_wfe),
    .deep_sleep_i(deep), .pdown_sel_i(pdsel), .reg_lp_sel_i(lpsel),
    .line_pend_i(pend), .line_irq_mode_i(irqm), .line_irq_en_i(irqe), .line_evt_mode_i(evtm),
    .rtc_alarm_i(rtc_alarm), .wake_pin_i(wake_pin), .clk_sel_wr_i(sel_wr), .clk_sel_val_i(sel_val),
    .wdg_start_i(wdg_start), .rtc_en_i(rtc_en), .lsi_en_i(lsi_en), .lse_en_i(lse_en),
    .core_clk_en_o(clk_en), .pll_off_o(pll_off), .hse_off_o(hse_off), .hsi_off_o(hsi_off),
    .reg_lp_req_o(reg_lp), .reg_off_o(reg_off), .core_dom_en_o(dom_en), .sysclk_sel_o(sysclk),
    .wake_done_o(wake_done), .sys_rst_req_o(sys_rst), .wdg_run_o(wdg_run), .rtc_run_o(rtc_run),
    .lsi_run_o(lsi_run), .lse_run_o(lse_run));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 run, 1 entering, 2 stop, 3 waking, 4 standby
  int m_mode = 0, m_rem = 0;
  bit m_lp = 0, m_wfe = 0, m_sb = 0, m_wd = 0, m_sr = 0, m_wdg = 0;
  bit m_rtc = 0, m_lsi = 0, m_lse = 0;
  int m_sel = 0;
  bit m_valid = 0;

  always @(posedge clk) begin
    m_valid <= 1;
    if (rst) begin
      m_mode <= 0; m_rem <= 0; m_lp <= 0; m_wfe <= 0; m_sb <= 0; m_wd <= 0; m_sr <= 0;
      m_wdg <= 0; m_rtc <= 0; m_lsi <= 0; m_lse <= 0; m_sel <= 0;
    end else begin
      m_wdg <= m_wdg | wdg_start;
      m_rtc <= rtc_en; m_lsi <= lsi_en; m_lse <= lse_en;
      m_wd <= 0; m_sr <= 0;
      case (m_mode)
        0: begin
          if (sel_wr) m_sel <= sel_val;
          if (sleep_req && deep && pend == 0 && !rtc_alarm) begin
            m_mode <= 1; m_lp <= lpsel; m_wfe <= is_wfe; m_sb <= pdsel;
          end
        end
        1: begin
          if (pend != 0 || rtc_alarm) m_mode <= 0;
          else m_mode <= m_sb ? 4 : 2;
        end
        2: begin
          if (m_wfe ? ((pend & evtm) != 0) : ((pend & irqm & irqe) != 0)) begin
            m_mode <= 3; m_rem <= m_lp ? REG + RC : RC;
          end
        end
        3: begin
          m_rem <= m_rem - 1;
          if (m_rem == 1) begin m_mode <= 0; m_wd <= 1; m_sel <= 0; end
        end
        4: if (wake_pin || rtc_alarm) begin m_mode <= 0; m_sr <= 1; m_sel <= 0; end
        default: m_mode <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R1", "core_clk_en", clk_en, m_mode == 0);
      chk("R1", "pll_off", pll_off, m_mode >= 2);
      chk("R1", "hse_off", hse_off, m_mode >= 2);
      chk("R8", "hsi_off", hsi_off, (m_mode == 2 || m_mode == 4 || (m_mode == 3 && m_rem > RC)));
      chk("R7", "reg_lp_req", reg_lp, m_mode == 2 && m_lp);
      chk("R2", "reg_off", reg_off, m_mode == 4);
      chk("R2", "core_dom_en", dom_en, m_mode != 4);
      chk("R9", "sysclk_sel", sysclk, m_sel);
      chk("R9", "wake_done", wake_done, m_wd);
      chk("R10", "sys_rst_req", sys_rst, m_sr);
      chk("R11", "wdg_run", wdg_run, m_wdg);
      chk("R11", "rtc_run", rtc_run, m_rtc);
      chk("R11", "lsi_run", lsi_run, m_lsi);
      chk("R11", "lse_run", lse_run, m_lse);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input bit wfe, input bit sb, input bit lp);
    deep = 1; pdsel = sb; lpsel = lp; is_wfe = wfe; sleep_req = 1;
    tick();
    sleep_req = 0;
  endtask

  task automatic measure_wake(input string rq, input int exp_lat);
    int k;
    k = 0;
    while (!wake_done && k < 40) begin tick(); k++; end
    chk(rq, "wake latency (negedges)", k, exp_lat + 1);
  endtask

  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    // R12 reset state
    chk("R12", "clk_en after reset", clk_en, 1);
    chk("R12", "sysclk after reset", sysclk, 0);
    chk("R12", "wdg_run after reset", wdg_run, 0);
    chk("R12", "wake_done after reset", wake_done, 0);

    rtc_en = 1; lsi_en = 1; lse_en = 1;
    sel_wr = 1; sel_val = 2'd2; tick(); sel_wr = 0; tick();
    chk("R9", "sysclk written to PLL", sysclk, 2);

    // R3: deep-sleep clear
    deep = 0; sleep_req = 1; tick(); sleep_req = 0; tick();
    chk("R3", "clk_en deep=0", clk_en, 1);
    // R3: line pending
    pend = 4'b0100; request(0, 0, 0); tick();
    chk("R3", "clk_en with pending line", clk_en, 1);
    pend = '0;
    rtc_alarm = 1; request(0, 0, 0); tick();
    chk("R3", "clk_en with rtc alarm", clk_en, 1);
    rtc_alarm = 0;

    // R1 + R5: WFI stop, main regulator
    irqm = '0; irqe = '0; evtm = 4'b0001;
    request(0, 0, 0);
    chk("R1", "clk gated in entry", clk_en, 0);
    tick();
    chk("R1", "pll off in stop", pll_off, 1);
    chk("R7", "reg_lp 0 in stop", reg_lp, 0);
    pend = 4'b0001; tick(4);
    chk("R5", "event-mode line does not wake WFI", hsi_off, 1);
    irqm = 4'b0001; tick(2);
    chk("R5", "irq line without enable", hsi_off, 1);
    irqe = 4'b0001;
    measure_wake("R8", RC);
    chk("R9", "sysclk RC on wake", sysclk, 0);
    tick();
    chk("R9", "wake_done one cycle", wake_done, 0);
    pend = '0; irqm = '0; irqe = '0; evtm = '0;

    // R6 + R7 + R8: WFE stop, low-power regulator
    wdg_start = 1; tick(); wdg_start = 0;
    request(1, 0, 1); tick();
    chk("R7", "reg_lp 1 in stop", reg_lp, 1);
    irqm = 4'b1000; irqe = 4'b1000; pend = 4'b1000; tick(4);
    chk("R6", "irq line does not wake WFE", clk_en, 0);
    chk("R6", "still in stop", pll_off, 1);
    evtm = 4'b1000;
    measure_wake("R8", REG + RC);
    chk("R11", "wdg still running", wdg_run, 1);
    pend = '0; irqm = '0; irqe = '0; evtm = '0;
    tick();

    // R4: cancel in entry cycle
    request(0, 0, 0);
    chk("R4", "in entry", clk_en, 0);
    pend = 4'b0010; tick();
    chk("R4", "back to run", clk_en, 1);
    pend = '0; tick(2);
    chk("R4", "stays in run", pll_off, 0);

    // R2 + R10: standby, wake pin
    sel_wr = 1; sel_val = 2'd1; tick(); sel_wr = 0;
    request(0, 1, 0); tick();
    chk("R2", "reg_off in standby", reg_off, 1);
    chk("R2", "domain off in standby", dom_en, 0);
    chk("R11", "rtc_run in standby", rtc_run, 1);
    tick(3);
    wake_pin = 1; tick(); wake_pin = 0;
    chk("R10", "sys_rst_req pulse", sys_rst, 1);
    chk("R10", "sysclk RC after standby", sysclk, 0);
    tick();
    chk("R10", "sys_rst_req one cycle", sys_rst, 0);
    // standby exit by alarm
    request(1, 1, 1); tick(2);
    rtc_alarm = 1; tick(); rtc_alarm = 0;
    chk("R10", "alarm leaves standby", sys_rst, 1);
    tick();

    // R11: always-on enables in stop, watchdog cleared only by reset
    request(0, 0, 0); tick();
    lse_en = 0; lsi_en = 0; tick(2);
    chk("R11", "lse follows in stop", lse_run, 0);
    chk("R11", "lsi follows in stop", lsi_run, 0);
    rst = 1; tick(2); rst = 0; tick();
    chk("R11", "wdg cleared by reset", wdg_run, 0);
    chk("R12", "run after reset", clk_en, 1);

    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule